// File: doc/BRIEF.md
# SPI Baud Parameter Selector

This block turns a precomputed clock ratio into the two settings of a two-stage SPI clock prescaler. The ratio R is the main clock frequency divided by the wanted SPI bit rate, already reduced to an integer. The first prescale stage is a power-of-two coarse divider chosen by a 2-bit select, and the second is a 6-bit fine divider. The block finds the smallest coarse select whose fine setting lands in the legal window. When the requested rate lies outside what the prescaler can produce, it returns the nearest legal setting and raises a clamp flag.

Software or a configuration sequencer pulses `start_i` for one cycle with R on `ratio_i`. The block then walks the coarse select upward from zero, testing one candidate per clock. It reports the result with a single-cycle `done_o` pulse, and the outputs hold their values until the next result. A start that arrives during a search is dropped.

Top module: `spi_baud_search`

## Requirements
- R1: After reset `done_o`, `presc_o`, `brg_o` and `clamp_o` are all zero.
- R2: For coarse select d = 0, 1, 2, 3 in that order, the candidate is C = R >> (d+2) (R divided by 4·2^d, truncated). The first d with 5 ≤ C ≤ 64 yields `presc_o` = d, `brg_o` = C−1 and `clamp_o` = 0.
- R3: If R < 20, so that C < 5 at d = 0, the result is `presc_o` = 0, `brg_o` = 4 and `clamp_o` = 1.
- R4: If C > 64 for every d, so that R ≥ 2080, the result is `presc_o` = 3, `brg_o` = 63 and `clamp_o` = 1.
- R5: A start is sampled at a rising edge. `done_o` rises d+1 clock edges later, where d is the coarse select that ended the search. This is four edges in the too-slow case.
- R6: A `start_i` pulse while a search is in progress has no effect: no extra `done_o` appears, and the result belongs to the ratio that started the search.
- R7: `done_o` stays high for exactly one cycle. `presc_o`, `brg_o` and `clamp_o` keep their values until the next `done_o`.
- R8: Every reported `brg_o` is at least 4, and `clamp_o` = 1 only with one of the two limit settings: (0, 4) or (3, 63).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a search |
| ratio_i | input | RATIO_W | Main clock / target SPI rate, sampled with start_i |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| presc_o | output | PRESC_W | Coarse power-of-two prescale select |
| brg_o | output | BRG_W | Fine divider setting (divide value minus one) |
| clamp_o | output | 1 | Request was out of range and was clamped |

## Verification
The assertions assume that `ratio_i` matters only in the cycle `start_i` is sampled while idle. They also assume that `start_i` can arrive at any time, including mid-search. The checks on R8 further rely on a below-floor candidate never appearing after the first coarse step. That follows from the ratio being captured once and never changing during a search. The stimulus holds R stable only for the start cycle and changes it freely afterwards. It draws random ratios from bands aimed at each coarse step and at both clamp regions, and adds directed values on every window edge (19, 20, 259, 260, 2079, 2080, 0, full scale). It also issues starts while busy, and a start in the same cycle that `done_o` is high.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;

   typedef enum logic [0:0] {
      ST_IDLE   = 1'b0,
      ST_SEARCH = 1'b1
   } srch_state_t;

   // classification of one fine-divider candidate
   typedef enum logic [1:0] {
      VD_BELOW = 2'd0,   // candidate under the legal window (rate too fast)
      VD_FIT   = 2'd1,   // candidate inside the window
      VD_ABOVE = 2'd2    // candidate over the window, try next coarse step
   } verdict_t;

endpackage

// File: rtl/baud_probe.sv
module baud_probe
   import spi_baud_pkg::*;
#(
   parameter int RATIO_W   = 16,
   parameter int PRESC_W   = 2,
   parameter int BRG_W     = 6,
   parameter int BRG_FLOOR = 4
) (
   input  logic [RATIO_W-1:0] ratio_i,
   input  logic [PRESC_W-1:0] presc_i,
   output verdict_t           verdict_o,
   output logic [BRG_W-1:0]   brg_fit_o
);

   localparam int NCAND    = 2 ** PRESC_W;
   localparam int BRG_CEIL = (2 ** BRG_W) - 1;
   localparam logic [RATIO_W-1:0] LO_LIM = RATIO_W'(BRG_FLOOR + 1);
   localparam logic [RATIO_W-1:0] HI_LIM = RATIO_W'(BRG_CEIL + 1);

   logic [RATIO_W-1:0] cand [NCAND];
   logic [RATIO_W-1:0] sel;

   // one shifter per coarse step; the 4 << d divisor becomes a shift by d+2
   for (genvar g = 0; g < NCAND; g++) begin : g_cand
      assign cand[g] = ratio_i >> (g + 2);
   end

   assign sel = cand[presc_i];

   always_comb begin
      if (sel < LO_LIM)
         verdict_o = VD_BELOW;
      else if (sel <= HI_LIM)
         verdict_o = VD_FIT;
      else
         verdict_o = VD_ABOVE;
   end

   // sel is in [FLOOR+1, CEIL+1]; low bits minus one wrap correctly at CEIL+1
   assign brg_fit_o = sel[BRG_W-1:0] - BRG_W'(1);

endmodule

// File: rtl/baud_search_fsm.sv
module baud_search_fsm
   import spi_baud_pkg::*;
#(
   parameter int RATIO_W   = 16,
   parameter int PRESC_W   = 2,
   parameter int BRG_W     = 6,
   parameter int BRG_FLOOR = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [RATIO_W-1:0] ratio_i,
   input  verdict_t           verdict_i,
   input  logic [BRG_W-1:0]   brg_fit_i,
   output logic [RATIO_W-1:0] ratio_q_o,
   output logic [PRESC_W-1:0] presc_q_o,
   output logic               done_o,
   output logic [PRESC_W-1:0] presc_o,
   output logic [BRG_W-1:0]   brg_o,
   output logic               clamp_o
);

   localparam logic [PRESC_W-1:0] PRESC_LAST = {PRESC_W{1'b1}};
   localparam logic [BRG_W-1:0]   BRG_TOP    = {BRG_W{1'b1}};
   localparam logic [BRG_W-1:0]   BRG_BOT    = BRG_W'(BRG_FLOOR);

   srch_state_t        state_q;
   logic [RATIO_W-1:0] ratio_q;
   logic [PRESC_W-1:0] step_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ratio_q <= '0;
         step_q  <= '0;
         done_o  <= 1'b0;
         presc_o <= '0;
         brg_o   <= '0;
         clamp_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  ratio_q <= ratio_i;
                  step_q  <= '0;
                  state_q <= ST_SEARCH;
               end
            end
            ST_SEARCH: begin
               unique case (verdict_i)
                  VD_BELOW: begin
                     presc_o <= step_q;
                     brg_o   <= BRG_BOT;
                     clamp_o <= 1'b1;
                     done_o  <= 1'b1;
                     state_q <= ST_IDLE;
                  end
                  VD_FIT: begin
                     presc_o <= step_q;
                     brg_o   <= brg_fit_i;
                     clamp_o <= 1'b0;
                     done_o  <= 1'b1;
                     state_q <= ST_IDLE;
                  end
                  default: begin
                     if (step_q == PRESC_LAST) begin
                        presc_o <= PRESC_LAST;
                        brg_o   <= BRG_TOP;
                        clamp_o <= 1'b1;
                        done_o  <= 1'b1;
                        state_q <= ST_IDLE;
                     end else begin
                        step_q <= step_q + 1'b1;
                     end
                  end
               endcase
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign ratio_q_o = ratio_q;
   assign presc_q_o = step_q;

   // R6: the captured ratio cannot be replaced while a search runs
   a_r6_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SEARCH && start_i) |=> $stable(ratio_q));

   // R5: an accepted start always begins at the smallest coarse step
   a_r5_first_step: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && start_i) |=> (step_q == '0 && state_q == ST_SEARCH));

   // R2: a too-fast verdict is only possible at the first coarse step
   a_r2_below_only_first: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SEARCH && verdict_i == VD_BELOW) |-> step_q == '0);

   // R7: done is a single-cycle pulse
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: rtl/spi_baud_search.sv
module spi_baud_search
   import spi_baud_pkg::*;
#(
   parameter int RATIO_W   = 16,
   parameter int PRESC_W   = 2,
   parameter int BRG_W     = 6,
   parameter int BRG_FLOOR = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [RATIO_W-1:0] ratio_i,
   output logic               done_o,
   output logic [PRESC_W-1:0] presc_o,
   output logic [BRG_W-1:0]   brg_o,
   output logic               clamp_o
);

   localparam int NCAND    = 2 ** PRESC_W;
   localparam int BRG_CEIL = (2 ** BRG_W) - 1;

   // elaboration-time parameter checks
   if (PRESC_W < 1 || PRESC_W > 4) begin : g_bad_presc
      $error("spi_baud_search: PRESC_W out of supported range");
   end
   if (BRG_W < 2) begin : g_bad_brgw
      $error("spi_baud_search: BRG_W too small");
   end
   if (BRG_FLOOR < 1 || BRG_FLOOR >= BRG_CEIL) begin : g_bad_floor
      $error("spi_baud_search: BRG_FLOOR must lie below the fine divider maximum");
   end
   if (RATIO_W <= NCAND + 1) begin : g_bad_ratio
      $error("spi_baud_search: RATIO_W too narrow for the largest shift");
   end

   logic [RATIO_W-1:0] ratio_q;
   logic [PRESC_W-1:0] step_q;
   verdict_t           verdict;
   logic [BRG_W-1:0]   brg_fit;

   baud_probe #(
      .RATIO_W   (RATIO_W),
      .PRESC_W   (PRESC_W),
      .BRG_W     (BRG_W),
      .BRG_FLOOR (BRG_FLOOR)
   ) u_probe (
      .ratio_i   (ratio_q),
      .presc_i   (step_q),
      .verdict_o (verdict),
      .brg_fit_o (brg_fit)
   );

   baud_search_fsm #(
      .RATIO_W   (RATIO_W),
      .PRESC_W   (PRESC_W),
      .BRG_W     (BRG_W),
      .BRG_FLOOR (BRG_FLOOR)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .ratio_i   (ratio_i),
      .verdict_i (verdict),
      .brg_fit_i (brg_fit),
      .ratio_q_o (ratio_q),
      .presc_q_o (step_q),
      .done_o    (done_o),
      .presc_o   (presc_o),
      .brg_o     (brg_o),
      .clamp_o   (clamp_o)
   );

   // R8: every reported fine setting respects the floor
   a_r8_brg_floor: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> brg_o >= BRG_W'(BRG_FLOOR));

   // R8: a clamped result is one of the two limit settings
   a_r8_clamp_limits: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && clamp_o) |->
         ((presc_o == '0 && brg_o == BRG_W'(BRG_FLOOR)) ||
          (presc_o == {PRESC_W{1'b1}} && brg_o == {BRG_W{1'b1}})));

   // R7: results hold between done pulses
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(presc_o) && $stable(brg_o) && $stable(clamp_o)));

endmodule

// File: tb/tb_spi_baud_search.sv
`timescale 1ns/1ps
module tb_spi_baud_search;

   localparam int RATIO_W = 16;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start_i = 1'b0;
   logic [RATIO_W-1:0] ratio_i = '0;
   logic               done_o;
   logic [1:0]         presc_o;
   logic [5:0]         brg_o;
   logic               clamp_o;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   spi_baud_search dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .ratio_i (ratio_i),
      .done_o  (done_o),
      .presc_o (presc_o),
      .brg_o   (brg_o),
      .clamp_o (clamp_o)
   );

   function automatic void model(input int r, output int d, output int b,
                                 output int c, output int lat);
      d = 3; b = 63; c = 1; lat = 4;
      for (int dd = 0; dd < 4; dd++) begin
         int cand;
         cand = r >> (dd + 2);
         if (cand < 5) begin
            d = dd; b = 4; c = 1; lat = dd + 1;
            return;
         end
         if (cand <= 64) begin
            d = dd; b = cand - 1; c = 0; lat = dd + 1;
            return;
         end
      end
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // result packed as presc*1000 + brg*10 + clamp for readable messages
   task automatic check_result(input string req, input int d, input int b, input int c);
      int act, exp;
      act = int'(presc_o) * 1000 + int'(brg_o) * 10 + int'(clamp_o);
      exp = d * 1000 + b * 10 + c;
      check(act == exp, req, act, exp);
   endtask

   // issue one search; optionally a second start (stray_r) one cycle later
   task automatic run(input int r, input string req, input bit stray, input int stray_r);
      int d, b, c, lat, n;
      model(r, d, b, c, lat);
      @(negedge clk);
      start_i = 1'b1;
      ratio_i = RATIO_W'(r);
      @(negedge clk);
      start_i = 1'b0;
      ratio_i = RATIO_W'(r ^ 16'h5a5a);
      check(done_o == 1'b0, {req, " done low after start edge (R5)"}, done_o, 0);
      if (stray) begin
         start_i = 1'b1;
         ratio_i = RATIO_W'(stray_r);
      end
      n = 0;
      for (int k = 1; k <= 8; k++) begin
         if (k > 1) begin
            start_i = 1'b0;
         end
         @(negedge clk);
         if (done_o) begin
            n = k;
            break;
         end
      end
      start_i = 1'b0;
      check(n == lat, {req, " latency (R5)"}, n, lat);
      check_result(req, d, b, c);
   endtask

   initial begin
      void'($urandom(32'h5eed_0b0d));
      repeat (3) @(negedge clk);
      // R1: reset state
      check(done_o == 1'b0, "R1 done", done_o, 0);
      check(presc_o == 2'd0 && brg_o == 6'd0 && clamp_o == 1'b0, "R1 outputs",
            int'(presc_o) * 1000 + int'(brg_o) * 10 + int'(clamp_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed window edges
      run(20,    "R2 lowest fit",          0, 0);
      run(19,    "R3 just too fast",       0, 0);
      run(0,     "R3 zero ratio",          0, 0);
      run(259,   "R2 top of step0",        0, 0);
      run(260,   "R2 first of step1",      0, 0);
      run(1000,  "R2 step2",               0, 0);
      run(2079,  "R2 top of step3",        0, 0);
      run(2080,  "R4 just too slow",       0, 0);
      run(65535, "R4 full scale",          0, 0);

      // R6: stray start during a long search
      run(2080, "R6 stray start ignored", 1, 100);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check(done_o == 1'b0, "R6 no extra done", done_o, 0);
      end
      check_result("R7 outputs held", 3, 63, 1);

      // R7: pulse width and hold, then a start in the done cycle
      begin
         int d, b, c, lat;
         model(300, d, b, c, lat);
         @(negedge clk);
         start_i = 1'b1; ratio_i = 16'd300;
         @(negedge clk);
         start_i = 1'b0;
         @(negedge clk);
         @(negedge clk);
         check(done_o == 1'b1, "R7 done present", done_o, 1);
         start_i = 1'b1; ratio_i = 16'd50;   // accepted in the done cycle
         @(negedge clk);
         start_i = 1'b0;
         check(done_o == 1'b0, "R7 single-cycle done", done_o, 0);
         check_result("R7 hold after done", d, b, c);
         @(negedge clk);
         check(done_o == 1'b1, "R7 back-to-back result", done_o, 1);
         check_result("R2 back-to-back value", 0, 11, 0);
      end

      // constrained random across bands
      for (int i = 0; i < 60; i++) begin
         int band, r;
         band = int'($urandom % 6);
         case (band)
            0: r = int'($urandom % 20);
            1: r = 20 + int'($urandom % 240);
            2: r = 260 + int'($urandom % 260);
            3: r = 520 + int'($urandom % 520);
            4: r = 1040 + int'($urandom % 1040);
            default: r = 2080 + int'($urandom % (65536 - 2080));
         endcase
         run(r, "R2/R3/R4 random", 0, 0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule